// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block picks the three divider fields of a PLL whose output frequency is the input frequency times (M+1)/(N+1), divided by (P+1). After a one-cycle `start` pulse it takes the input clock rate, the wanted output rate and an upper bound for each field. It raises `busy` and works through the candidates on its own. When it finishes it pulses `done` and presents M, N, P and the output rate that those settings give.

A small fixed table of known-good settings is checked first. On a table miss, both rates are cut to whole kHz. The engine then walks every (N, P) pair, N outer and P inner. For each pair it derives M with a truncating formula. It drops any setting that would overshoot the request and keeps the one that falls short by the least. Every quotient comes from one shared iterative restoring divider, so each candidate costs a few dozen cycles. An exact hit ends the walk at once.

Top module: `pll_param_search`

## Requirements
- R1: Both rates are cut to whole kHz by truncating division by 1000 before any search arithmetic. The reported `rate_hz` of a searched result is the chosen kHz rate times 1000.
- R2: When `in_rate_hz` is 24000000 and `req_rate_hz` is 250000000, the result is M=124, N=1, P=5 and `rate_hz` equals `req_rate_hz`, with no search done.
- R3: Candidates are visited with N from 0 up to `n_max` as the outer loop and P from 0 up to `p_max` as the inner loop.
- R4: For each candidate, M = floor(req_khz*(P+1)/in_khz)*(N+1). A candidate whose M is above `m_max` is skipped.
- R5: A candidate's output in kHz is in_khz*floor((M+1)/(N+1))/(P+1), with the inner division done first.
- R6: A candidate whose output is above req_khz is rejected, so a reported rate never exceeds the request.
- R7: A candidate that gives exactly req_khz ends the search at once. That candidate is the result.
- R8: Among accepted candidates the one with the smallest req_khz minus output is kept. On a tie, the earlier one in visit order is kept.
- R9: When no candidate is accepted, M, N, P and `rate_hz` are all zero and `no_solution` is 1 while `done` is high.
- R10: `busy` rises on the cycle after an accepted `start` and stays high until the cycle `done` is high. A `start` while `busy` is high has no effect.
- R11: After reset, `busy`, `done`, `no_solution` and all result outputs are 0. `done` is a one-cycle pulse, and the result outputs change only in that cycle.
- R12: An input rate below 1000 Hz (in_khz of zero) gives the no-solution result of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search |
| in_rate_hz | input | 32 | Input clock rate in Hz, sampled with `start` |
| req_rate_hz | input | 32 | Requested output rate in Hz, sampled with `start` |
| m_max | input | 8 | Largest allowed M |
| n_max | input | 6 | Largest allowed N |
| p_max | input | 6 | Largest allowed P |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: result valid |
| no_solution | output | 1 | No candidate was accepted |
| m_out | output | 8 | Chosen numerator field |
| n_out | output | 6 | Chosen denominator field |
| p_out | output | 6 | Chosen post-divider field |
| rate_hz | output | 32 | Output rate of the chosen setting in Hz |

## Verification
Each result is only visible at the pulse of `done`. A corrupted loop counter, a bad best-so-far register or a stale quotient therefore shows up as a wrong field or rate at the end of that same run. A stuck state shows up as a `done` that never arrives. A broken early exit shows up as a run that finishes far later than an exact hit early in the order allows. The sweeps compare every run against an arithmetic model of the requirements. They cover small field bounds, so the tie-breaking, the overshoot rejection and the M bound are all hit many times.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int PKG_M_W    = 8;
  localparam int PKG_NP_W   = 6;
  localparam int PKG_RATE_W = 32;
  localparam int NUM_PRESETS = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KIN, ST_KREQ, ST_ISSUE, ST_NUM, ST_RAT, ST_OUT, ST_FIN
  } search_state_t;

  typedef struct packed {
    logic [PKG_RATE_W-1:0] in_hz;
    logic [PKG_RATE_W-1:0] req_hz;
    logic [PKG_M_W-1:0]    m;
    logic [PKG_NP_W-1:0]   n;
    logic [PKG_NP_W-1:0]   p;
  } preset_t;

  function automatic preset_t preset_at(int idx);
    preset_t e;
    e = '0;
    if (idx == 0) begin
      e.in_hz  = 32'd24000000;
      e.req_hz = 32'd250000000;
      e.m      = 8'd124;
      e.n      = 6'd1;
      e.p      = 6'd5;
    end
    return e;
  endfunction
endpackage

// File: rtl/pll_iter_div.sv
module pll_iter_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, dv_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quot[W-1]};
  assign diff    = shifted - {1'b0, dv_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dv_q  <= '0;
      quot  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q <= '0;
        quot  <= dividend;
        dv_q  <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quot  <= {quot[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quot  <= {quot[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_preset_match.sv
module pll_preset_match
  import pll_search_pkg::*;
#(
  parameter int MW  = PKG_M_W,
  parameter int NPW = PKG_NP_W,
  parameter int RW  = PKG_RATE_W
) (
  input  logic [RW-1:0]  in_hz,
  input  logic [RW-1:0]  req_hz,
  output logic           hit,
  output logic [MW-1:0]  m,
  output logic [NPW-1:0] n,
  output logic [NPW-1:0] p
);
  logic [NUM_PRESETS-1:0] hitv;

  for (genvar i = 0; i < NUM_PRESETS; i++) begin : g_entry
    localparam preset_t E = preset_at(i);
    assign hitv[i] = (in_hz == RW'(E.in_hz)) && (req_hz == RW'(E.req_hz));
  end

  always_comb begin
    hit = 1'b0;
    m   = '0;
    n   = '0;
    p   = '0;
    for (int i = NUM_PRESETS - 1; i >= 0; i--) begin
      if (hitv[i]) begin
        hit = 1'b1;
        m   = MW'(preset_at(i).m);
        n   = NPW'(preset_at(i).n);
        p   = NPW'(preset_at(i).p);
      end
    end
  end
endmodule

// File: rtl/pll_param_search.sv
module pll_param_search
  import pll_search_pkg::*;
#(
  parameter int MW      = PKG_M_W,
  parameter int NPW     = PKG_NP_W,
  parameter int RW      = PKG_RATE_W,
  parameter int KHZ_DIV = 1000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [RW-1:0]  in_rate_hz,
  input  logic [RW-1:0]  req_rate_hz,
  input  logic [MW-1:0]  m_max,
  input  logic [NPW-1:0] n_max,
  input  logic [NPW-1:0] p_max,
  output logic           busy,
  output logic           done,
  output logic           no_solution,
  output logic [MW-1:0]  m_out,
  output logic [NPW-1:0] n_out,
  output logic [NPW-1:0] p_out,
  output logic [RW-1:0]  rate_hz
);
  localparam int MPW = RW + NPW + 1;

  search_state_t  state;
  logic [RW-1:0]  req_q, ikhz, rkhz, dvd, dvs, best_hz, best_short;
  logic [MW-1:0]  mmax_q, m_c, best_m;
  logic [NPW-1:0] nmax_q, pmax_q, n_i, p_i, best_n, best_p;
  logic           found, div_go, div_fin;
  logic [RW-1:0]  div_q;

  logic           pre_hit;
  logic [MW-1:0]  pre_m;
  logic [NPW-1:0] pre_n, pre_p;

  logic [RW-1:0]  n_ext, p_ext, shortfall;
  logic [MPW-1:0] mcand;
  logic           m_over, c_over, better, walk_end;

  pll_iter_div #(.W(RW)) div_i (
    .clk(clk), .rst(rst), .go(div_go), .dividend(dvd), .divisor(dvs),
    .fin(div_fin), .quot(div_q)
  );

  pll_preset_match #(.MW(MW), .NPW(NPW), .RW(RW)) preset_i (
    .in_hz(in_rate_hz), .req_hz(req_rate_hz),
    .hit(pre_hit), .m(pre_m), .n(pre_n), .p(pre_p)
  );

  assign n_ext     = RW'(n_i) + RW'(1);
  assign p_ext     = RW'(p_i) + RW'(1);
  assign mcand     = MPW'(div_q) * MPW'(n_ext);
  assign m_over    = mcand > MPW'(mmax_q);
  assign c_over    = div_q > rkhz;
  assign shortfall = rkhz - div_q;
  assign better    = !found || (shortfall < best_short);
  assign walk_end  = (p_i == pmax_q) && (n_i == nmax_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      {req_q, ikhz, rkhz, dvd, dvs, best_hz, best_short} <= '0;
      {mmax_q, m_c, best_m} <= '0;
      {nmax_q, pmax_q, n_i, p_i, best_n, best_p} <= '0;
      found <= 1'b0;
      div_go <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
      no_solution <= 1'b0;
      m_out <= '0;
      n_out <= '0;
      p_out <= '0;
      rate_hz <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          busy   <= 1'b1;
          req_q  <= req_rate_hz;
          mmax_q <= m_max;
          nmax_q <= n_max;
          pmax_q <= p_max;
          found  <= pre_hit;
          best_m <= pre_hit ? pre_m : '0;
          best_n <= pre_hit ? pre_n : '0;
          best_p <= pre_hit ? pre_p : '0;
          best_hz <= pre_hit ? req_rate_hz : '0;
          best_short <= '0;
          if (pre_hit) state <= ST_FIN;
          else begin
            dvd <= in_rate_hz;
            dvs <= RW'(KHZ_DIV);
            div_go <= 1'b1;
            state <= ST_KIN;
          end
        end
        ST_KIN: if (div_fin) begin
          ikhz <= div_q;
          dvd <= req_q;
          dvs <= RW'(KHZ_DIV);
          div_go <= 1'b1;
          state <= ST_KREQ;
        end
        ST_KREQ: if (div_fin) begin
          rkhz <= div_q;
          n_i <= '0;
          p_i <= '0;
          state <= (ikhz == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: begin
          dvd <= rkhz * p_ext;
          dvs <= ikhz;
          div_go <= 1'b1;
          state <= ST_NUM;
        end
        ST_NUM: if (div_fin) begin
          if (m_over) begin
            if (walk_end) state <= ST_FIN;
            else begin
              p_i <= (p_i == pmax_q) ? '0 : p_i + NPW'(1);
              n_i <= (p_i == pmax_q) ? n_i + NPW'(1) : n_i;
              state <= ST_ISSUE;
            end
          end else begin
            m_c <= mcand[MW-1:0];
            dvd <= RW'(mcand[MW-1:0]) + RW'(1);
            dvs <= n_ext;
            div_go <= 1'b1;
            state <= ST_RAT;
          end
        end
        ST_RAT: if (div_fin) begin
          dvd <= ikhz * div_q;
          dvs <= p_ext;
          div_go <= 1'b1;
          state <= ST_OUT;
        end
        ST_OUT: if (div_fin) begin
          if (!c_over && better) begin
            found <= 1'b1;
            best_m <= m_c;
            best_n <= n_i;
            best_p <= p_i;
            best_short <= shortfall;
            best_hz <= div_q * RW'(KHZ_DIV);
          end
          if ((!c_over && shortfall == '0) || walk_end) state <= ST_FIN;
          else begin
            p_i <= (p_i == pmax_q) ? '0 : p_i + NPW'(1);
            n_i <= (p_i == pmax_q) ? n_i + NPW'(1) : n_i;
            state <= ST_ISSUE;
          end
        end
        default: begin
          busy <= 1'b0;
          done <= 1'b1;
          no_solution <= !found;
          m_out <= best_m;
          n_out <= best_n;
          p_out <= best_p;
          rate_hz <= best_hz;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pll_param_search_chk.sv
module pll_param_search_chk #(
  parameter int MW  = 8,
  parameter int NPW = 6,
  parameter int RW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [RW-1:0]  req_rate_hz,
  input logic           busy,
  input logic           done,
  input logic           no_solution,
  input logic [MW-1:0]  m_out,
  input logic [NPW-1:0] n_out,
  input logic [NPW-1:0] p_out,
  input logic [RW-1:0]  rate_hz
);
  logic [RW-1:0] req_cap;
  always_ff @(posedge clk) begin
    if (rst) req_cap <= '0;
    else if (start && !busy) req_cap <= req_rate_hz;
  end

  // R10
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R10
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)) ##1 !done);

  // R11
  outputs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(m_out) && $stable(n_out) && $stable(p_out)
               && $stable(rate_hz) && $stable(no_solution)));

  // R9
  empty_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && no_solution) |-> (m_out == '0 && n_out == '0 && p_out == '0
                               && rate_hz == '0));

  // R6
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !no_solution) |-> (rate_hz <= req_cap));
endmodule

bind pll_param_search pll_param_search_chk #(.MW(MW), .NPW(NPW), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .req_rate_hz(req_rate_hz),
  .busy(busy), .done(done), .no_solution(no_solution),
  .m_out(m_out), .n_out(n_out), .p_out(p_out), .rate_hz(rate_hz)
);

// File: tb/pll_param_search_tb_top.sv
module pll_param_search_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] in_rate_hz = '0, req_rate_hz = '0;
  logic [7:0]  m_max = '0;
  logic [5:0]  n_max = '0, p_max = '0;
  logic        busy, done, no_solution;
  logic [7:0]  m_out;
  logic [5:0]  n_out, p_out;
  logic [31:0] rate_hz;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pll_param_search dut_i (
    .clk(clk), .rst(rst), .start(start), .in_rate_hz(in_rate_hz),
    .req_rate_hz(req_rate_hz), .m_max(m_max), .n_max(n_max), .p_max(p_max),
    .busy(busy), .done(done), .no_solution(no_solution),
    .m_out(m_out), .n_out(n_out), .p_out(p_out), .rate_hz(rate_hz)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void ref_model(input longint inhz, input longint reqhz,
                                    input longint mm, input longint nm, input longint pm,
                                    output longint em, output longint en, output longint ep,
                                    output longint erate, output bit enone);
    longint ik, rk, m, c, s, bs;
    bit found, stop;
    em = 0; en = 0; ep = 0; erate = 0; enone = 0;
    if (inhz == 24000000 && reqhz == 250000000) begin
      em = 124; en = 1; ep = 5; erate = reqhz;
      return;
    end
    ik = inhz / 1000;
    rk = reqhz / 1000;
    found = 0; stop = 0; bs = 0;
    if (ik != 0) begin
      for (longint n = 0; n <= nm && !stop; n++) begin
        for (longint p = 0; p <= pm && !stop; p++) begin
          m = (rk * (p + 1) / ik) * (n + 1);
          if (m <= mm) begin
            c = ik * ((m + 1) / (n + 1)) / (p + 1);
            if (c <= rk) begin
              s = rk - c;
              if (!found || s < bs) begin
                found = 1; bs = s; em = m; en = n; ep = p; erate = c * 1000;
              end
              if (s == 0) stop = 1;
            end
          end
        end
      end
    end
    enone = !found;
  endfunction

  task automatic run_case(input logic [31:0] inhz, input logic [31:0] reqhz,
                          input logic [7:0] mm, input logic [5:0] nm, input logic [5:0] pm,
                          input string tag, output int cyc);
    longint em, en, ep, erate;
    bit enone;
    @(negedge clk);
    in_rate_hz = inhz; req_rate_hz = reqhz; m_max = mm; n_max = nm; p_max = pm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, {tag, " done seen"}, done, 1);
    ref_model(inhz, reqhz, mm, nm, pm, em, en, ep, erate, enone);
    check(no_solution == enone, {tag, " no_solution"}, no_solution, enone);
    check(m_out == em[7:0] && n_out == en[5:0] && p_out == ep[5:0],
          {tag, " fields M*4096+N*64+P"}, m_out * 4096 + n_out * 64 + p_out,
          em * 4096 + en * 64 + ep);
    check(rate_hz == erate[31:0], {tag, " rate_hz"}, rate_hz, erate);
  endtask

  initial begin
    int cyc;
    logic [31:0] ins [4] = '{32'd24000000, 32'd25000000, 32'd33333000, 32'd1000999};
    logic [31:0] reqs [5] = '{32'd250000000, 32'd100000000, 32'd24000000, 32'd7000, 32'd0};
    logic [7:0]  mms [2] = '{8'd255, 8'd7};
    logic [5:0]  nms [2] = '{6'd2, 6'd1};
    logic [5:0]  pms [2] = '{6'd2, 6'd3};

    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !no_solution, "R11 reset flags", {busy, done, no_solution}, 0);
    check(m_out == 0 && n_out == 0 && p_out == 0 && rate_hz == 0, "R11 reset result", rate_hz, 0);
    rst = 1'b0;

    // R2 preset hit with tight bounds that a search could not reach
    run_case(32'd24000000, 32'd250000000, 8'd3, 6'd0, 6'd0, "R2 preset", cyc);
    check(cyc < 5, "R2 preset without search (cycles)", cyc, 2);

    // Sweep: R1 R3 R4 R5 R6 R8 R9 against the model
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 2; c++)
          for (int d = 0; d < 2; d++)
            run_case(ins[a], reqs[b], mms[c], nms[d], pms[d],
                     "R1 R3 R4 R5 R6 R8 R9 sweep", cyc);

    // R12 input below 1 kHz
    run_case(32'd999, 32'd5000, 8'd255, 6'd1, 6'd1, "R12 tiny input", cyc);
    check(no_solution == 1'b1, "R12 flag", no_solution, 1);

    // R9 every candidate overshoots: request below in_khz with N bound 0
    run_case(32'd24000000, 32'd1000000, 8'd255, 6'd0, 6'd3, "R9 all rejected", cyc);
    check(no_solution == 1'b1 && rate_hz == 0, "R9 zero result", rate_hz, 0);

    // R7 exact hit at N=1 P=0 ends a 64x64 walk early
    run_case(32'd24000000, 32'd24000000, 8'd255, 6'd63, 6'd63, "R7 exact", cyc);
    check(m_out == 2 && n_out == 1 && p_out == 0, "R7 exact fields M", m_out, 2);
    check(cyc < 12000, "R7 early finish (cycles)", cyc, 7000);

    // R10 start during busy is ignored
    @(negedge clk);
    in_rate_hz = 32'd24000000; req_rate_hz = 32'd24000000;
    m_max = 8'd255; n_max = 6'd2; p_max = 6'd2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R10 busy during run", busy, 1);
    in_rate_hz = 32'd25000000; req_rate_hz = 32'd7000; n_max = 6'd0; p_max = 6'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40000) begin
      check(busy == 1'b1, "R10 busy held until done", busy, 1);
      @(negedge clk);
      cyc++;
    end
    check(done && !busy, "R10 done ends busy", busy, 0);
    check(m_out == 2 && n_out == 1 && p_out == 0 && rate_hz == 32'd24000000,
          "R10 first request result kept", rate_hz, 24000000);

    // R11 one-cycle pulse and held result
    @(negedge clk);
    check(!done, "R11 done one cycle", done, 0);
    cyc = 0;
    repeat (400) begin
      @(negedge clk);
      if (done || busy) cyc++;
    end
    check(cyc == 0, "R10 ignored start launched nothing", cyc, 0);
    check(m_out == 2 && n_out == 1 && p_out == 0 && rate_hz == 32'd24000000,
          "R11 result held", rate_hz, 24000000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule